// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds a single load-linked reservation for one hardware thread. It decides whether a following store-conditional may complete. A load-linked request records an address, aligned down to a 16-byte granule, and arms the reservation. A store-conditional passes only if the reservation is still armed and its own aligned address falls in the same granule. Coherence snoops disarm the reservation at a coarser grain: the stored and snooped addresses are compared under a cache-block mask, which is a block input.

Each cacheable store-conditional gets a one-cycle response with a pass or fail result. Only a passing one is sent to memory. Store-conditionals tagged uncacheable skip the reservation check. They always go to memory and leave the held result, the reservation and the failure count as they were.

A saturating counter tracks consecutive failures and raises a warning pulse each time it reaches a multiple of a configurable period. A global clear strobe produces a wakeup pulse for the thread. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request stores its address with bits [3:0] forced to zero and arms the reservation, so a later store-conditional to any byte in that 16-byte granule can pass.
- R2: A passing store-conditional gives, one cycle later, sc_resp_valid=1, sc_result=1 and a one-cycle mem_fwd. It disarms the reservation and sets fail_count to 0.
- R3: A cacheable store-conditional fails if the reservation is disarmed or if its address with bits [3:0] zeroed differs from the stored address. It then gives sc_resp_valid=1, sc_result=0 and mem_fwd=0, and disarms the reservation.
- R4: A snoop disarms an armed reservation when (stored address & blk_mask) equals (snoop address & blk_mask). A snoop that does not match, or that arrives while the reservation is disarmed, has no effect.
- R5: A snoop and a store-conditional in the same cycle are resolved snoop first, so a store-conditional whose block the snoop hits fails.
- R6: An uncacheable store-conditional gives mem_fwd=1 one cycle later with sc_resp_valid=0. It leaves sc_result, the reservation and fail_count unchanged.
- R7: Each failing store-conditional increments fail_count by one. The count saturates at all ones.
- R8: livelock_warn pulses for one cycle, together with the failure response, whenever an increment brings fail_count to a nonzero multiple of WARN_PERIOD.
- R9: A gclr strobe gives a one-cycle wakeup pulse on the following cycle.
- R10: A new load-linked request replaces any existing reservation address.
- R11: After reset the reservation is disarmed and every output is 0.
- R12: When a load-linked and a store-conditional arrive in the same cycle, the store-conditional is judged against the previous reservation and the load-linked then arms the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_mask | input | ADDR_W | Cache-block mask used for snoop comparison |
| ll_valid | input | 1 | Load-linked request strobe |
| ll_addr | input | ADDR_W | Load-linked physical address |
| sc_valid | input | 1 | Store-conditional request strobe |
| sc_uncached | input | 1 | Store-conditional is uncacheable (bypass) |
| sc_addr | input | ADDR_W | Store-conditional physical address |
| snp_valid | input | 1 | Invalidating snoop strobe |
| snp_addr | input | ADDR_W | Snoop address |
| gclr | input | 1 | Global clear strobe |
| sc_resp_valid | output | 1 | Cacheable store-conditional decided this cycle |
| sc_result | output | 1 | Held result of the last cacheable store-conditional (1 pass, 0 fail) |
| mem_fwd | output | 1 | Store-conditional may go to memory |
| fail_count | output | CNT_W | Consecutive failure count |
| livelock_warn | output | 1 | Failure count reached a multiple of WARN_PERIOD |
| wakeup | output | 1 | Wakeup pulse after a global clear |

## Verification
Store-conditionals are tried in several ways: with no reservation, inside the reserved granule at different byte offsets, and in the neighbouring granule. This separates the 16-byte match from a full-address match. Snoops are sent inside the reserved block, one block away, and under a widened mask, which shows that the snoop uses the block mask and not the granule. Same-cycle pairings (snoop with store-conditional, load-linked with store-conditional) and uncacheable requests placed between reserve and commit check the resolution order. A long run of failures checks that warnings occur at the period and that the counter saturates.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    SC_IDLE   = 2'd0,
    SC_BYPASS = 2'd1,
    SC_PASS   = 2'd2,
    SC_FAIL   = 2'd3
  } sc_outcome_e;

endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] blk_mask,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              sc_consume,
  output logic              resv_live,
  output logic [ADDR_W-1:0] resv_addr
);

  localparam logic [ADDR_W-1:0] GRAN_KEEP = {{(ADDR_W-GRAN_LSB){1'b1}}, {GRAN_LSB{1'b0}}};

  logic              armed_q, armed_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              snp_hit;

  // snoop compares at block grain, ahead of any store-conditional
  always_comb begin
    snp_hit   = armed_q && snp_valid && ((addr_q & blk_mask) == (snp_addr & blk_mask));
    resv_live = armed_q && !snp_hit;
  end

  // load-linked wins over every clearing cause for the next state
  always_comb begin
    addr_en = ll_valid;
    addr_d  = ll_addr & GRAN_KEEP;
    if (ll_valid) begin
      armed_d = 1'b1;
    end else begin
      armed_d = resv_live && !sc_consume;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign resv_addr = addr_q;

endmodule

// File: rtl/llsc_fail_ctr.sv
module llsc_fail_ctr #(
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_evt,
  input  logic             pass_evt,
  output logic [CNT_W-1:0] count,
  output logic             warn
);

  localparam int SUB_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             warn_q, warn_d;
  logic             bump;
  logic             period_wrap;

  assign bump = fail_evt && !(&cnt_q);

  generate
    if (WARN_PERIOD > 1) begin : g_sub
      localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(WARN_PERIOD - 1);
      logic [SUB_W-1:0] sub_q, sub_d;

      assign period_wrap = (sub_q == SUB_LAST);

      always_comb begin
        sub_d = sub_q;
        if (pass_evt) begin
          sub_d = '0;
        end else if (bump) begin
          sub_d = period_wrap ? '0 : sub_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sub_q <= '0;
        end else if (pass_evt || bump) begin
          sub_q <= sub_d;
        end
      end
    end else begin : g_every
      assign period_wrap = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (pass_evt) begin
      cnt_d = '0;
    end else if (bump) begin
      cnt_d = cnt_q + 1'b1;
    end
    warn_d = bump && period_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      warn_q <= warn_d;
    end
  end

  assign count = cnt_q;
  assign warn  = warn_q;

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRAN_LSB    = 4,
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] blk_mask,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_valid,
  input  logic              sc_uncached,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              gclr,
  output logic              sc_resp_valid,
  output logic              sc_result,
  output logic              mem_fwd,
  output logic [CNT_W-1:0]  fail_count,
  output logic              livelock_warn,
  output logic              wakeup
);

  localparam logic [ADDR_W-1:0] GRAN_KEEP = {{(ADDR_W-GRAN_LSB){1'b1}}, {GRAN_LSB{1'b0}}};

  logic              resv_live;
  logic [ADDR_W-1:0] resv_addr;
  logic              sc_consume;
  logic              granule_eq;
  sc_outcome_e       outcome;

  logic resp_q, resp_d;
  logic res_q, res_d, res_en;
  logic fwd_q, fwd_d;
  logic wake_q;

  assign sc_consume = sc_valid && !sc_uncached;

  llsc_resv #(
    .ADDR_W   (ADDR_W),
    .GRAN_LSB (GRAN_LSB)
  ) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_mask   (blk_mask),
    .ll_valid   (ll_valid),
    .ll_addr    (ll_addr),
    .snp_valid  (snp_valid),
    .snp_addr   (snp_addr),
    .sc_consume (sc_consume),
    .resv_live  (resv_live),
    .resv_addr  (resv_addr)
  );

  // decide this cycle's store-conditional
  always_comb begin
    granule_eq = ((sc_addr & GRAN_KEEP) == resv_addr);
    if (!sc_valid) begin
      outcome = SC_IDLE;
    end else if (sc_uncached) begin
      outcome = SC_BYPASS;
    end else if (resv_live && granule_eq) begin
      outcome = SC_PASS;
    end else begin
      outcome = SC_FAIL;
    end
  end

  llsc_fail_ctr #(
    .CNT_W       (CNT_W),
    .WARN_PERIOD (WARN_PERIOD)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .fail_evt (outcome == SC_FAIL),
    .pass_evt (outcome == SC_PASS),
    .count    (fail_count),
    .warn     (livelock_warn)
  );

  always_comb begin
    resp_d = (outcome == SC_PASS) || (outcome == SC_FAIL);
    res_en = resp_d;
    res_d  = (outcome == SC_PASS);
    fwd_d  = (outcome == SC_PASS) || (outcome == SC_BYPASS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= 1'b0;
      fwd_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      resp_q <= resp_d;
      fwd_q  <= fwd_d;
      wake_q <= gclr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= 1'b0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign sc_resp_valid = resp_q;
  assign sc_result     = res_q;
  assign mem_fwd       = fwd_q;
  assign wakeup        = wake_q;

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] blk_mask,
  input logic              sc_valid,
  input logic              sc_uncached,
  input logic [ADDR_W-1:0] sc_addr,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              gclr,
  input logic              sc_resp_valid,
  input logic              sc_result,
  input logic              mem_fwd,
  input logic [CNT_W-1:0]  fail_count,
  input logic              livelock_warn,
  input logic              wakeup
);

  AST_FWD_NEEDS_SC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fwd |-> $past(sc_valid)); // R2

  AST_PASS_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_resp_valid && sc_result) |-> (fail_count == '0)); // R2

  AST_FAIL_BLOCKS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_resp_valid && !sc_result) |-> !mem_fwd); // R3

  AST_SNOOP_BEATS_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !sc_uncached && snp_valid &&
     ((sc_addr & blk_mask) == (snp_addr & blk_mask))) |=> !sc_result); // R5

  AST_RESP_FROM_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_resp_valid |-> $past(sc_valid && !sc_uncached)); // R6

  AST_BYPASS_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sc_valid && sc_uncached) |-> $stable(sc_result)); // R6

  AST_FAIL_MOVES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_resp_valid && !sc_result) |-> ((fail_count != $past(fail_count)) || (&fail_count))); // R7

  AST_WARN_WITH_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    livelock_warn |-> (sc_resp_valid && !sc_result)); // R8

  AST_WAKE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    gclr |=> wakeup); // R9

  AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |-> $past(gclr)); // R9

endmodule

bind llsc_monitor llsc_monitor_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .blk_mask      (blk_mask),
  .sc_valid      (sc_valid),
  .sc_uncached   (sc_uncached),
  .sc_addr       (sc_addr),
  .snp_valid     (snp_valid),
  .snp_addr      (snp_addr),
  .gclr          (gclr),
  .sc_resp_valid (sc_resp_valid),
  .sc_result     (sc_result),
  .mem_fwd       (mem_fwd),
  .fail_count    (fail_count),
  .livelock_warn (livelock_warn),
  .wakeup        (wakeup)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;

  localparam int AW   = 32;
  localparam int CW   = 4;
  localparam int PER  = 5;
  localparam int CMAX = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] blk_mask = 32'hFFFF_FFC0;
  logic          ll_valid = 1'b0;
  logic [AW-1:0] ll_addr = '0;
  logic          sc_valid = 1'b0;
  logic          sc_uncached = 1'b0;
  logic [AW-1:0] sc_addr = '0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          gclr = 1'b0;
  logic          sc_resp_valid, sc_result, mem_fwd, livelock_warn, wakeup;
  logic [CW-1:0] fail_count;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string phase = "R11 reset";

  // reference model state
  bit          m_flag = 1'b0;
  logic [31:0] m_addr = '0;
  int          m_cnt = 0;
  bit          e_resp = 1'b0, e_res = 1'b0, e_fwd = 1'b0, e_warn = 1'b0, e_wake = 1'b0;

  always #2 clk = ~clk;

  llsc_monitor #(
    .ADDR_W      (AW),
    .GRAN_LSB    (4),
    .CNT_W       (CW),
    .WARN_PERIOD (PER)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .blk_mask      (blk_mask),
    .ll_valid      (ll_valid),
    .ll_addr       (ll_addr),
    .sc_valid      (sc_valid),
    .sc_uncached   (sc_uncached),
    .sc_addr       (sc_addr),
    .snp_valid     (snp_valid),
    .snp_addr      (snp_addr),
    .gclr          (gclr),
    .sc_resp_valid (sc_resp_valid),
    .sc_result     (sc_result),
    .mem_fwd       (mem_fwd),
    .fail_count    (fail_count),
    .livelock_warn (livelock_warn),
    .wakeup        (wakeup)
  );

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    bit live;
    bit pass;
    if (!rst_n) begin
      m_flag = 0; m_addr = '0; m_cnt = 0;
      e_resp = 0; e_res = 0; e_fwd = 0; e_warn = 0; e_wake = 0;
    end else begin
      e_resp = 0; e_fwd = 0; e_warn = 0;
      e_wake = gclr;
      live = m_flag;
      if (snp_valid && m_flag && ((m_addr & blk_mask) == (snp_addr & blk_mask))) live = 0;
      if (sc_valid) begin
        if (sc_uncached) begin
          e_fwd = 1;
        end else begin
          pass   = live && ((sc_addr & ~32'hF) == m_addr);
          e_resp = 1;
          e_res  = pass;
          e_fwd  = pass;
          if (pass) begin
            m_cnt = 0;
          end else if (m_cnt < CMAX) begin
            m_cnt = m_cnt + 1;
            if (m_cnt % PER == 0) e_warn = 1;
          end
          live = 0;
        end
      end
      if (ll_valid) begin
        m_flag = 1;
        m_addr = ll_addr & ~32'hF;
      end else begin
        m_flag = live;
      end
    end
  end

  task automatic cmp1(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL [%s] %s actual=%0d expected=%0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp1("sc_resp_valid (R2/R3/R6)", int'(sc_resp_valid), int'(e_resp));
      cmp1("sc_result (R1/R2/R3/R4/R5)", int'(sc_result), int'(e_res));
      cmp1("mem_fwd (R2/R6)", int'(mem_fwd), int'(e_fwd));
      cmp1("fail_count (R7)", int'(fail_count), m_cnt);
      cmp1("livelock_warn (R8)", int'(livelock_warn), int'(e_warn));
      cmp1("wakeup (R9)", int'(wakeup), int'(e_wake));
    end
  end

  task automatic go();
    @(posedge clk);
    #1;
    ll_valid = 0; sc_valid = 0; sc_uncached = 0; snp_valid = 0; gclr = 0;
  endtask

  task automatic do_ll(logic [31:0] a);
    ll_valid = 1; ll_addr = a; go();
  endtask

  task automatic do_sc(logic [31:0] a, bit unc);
    sc_valid = 1; sc_addr = a; sc_uncached = unc; go();
  endtask

  task automatic do_snp(logic [31:0] a);
    snp_valid = 1; snp_addr = a; go();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL [watchdog] run did not finish actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    phase = "R11 reset";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    go(); go();

    phase = "R3 no reservation";
    do_sc(32'h0000_0100, 0); go();

    phase = "R1 R2 granule pass";
    do_ll(32'h1000_0104);
    do_sc(32'h1000_010C, 0); go();
    phase = "R2 reservation consumed";
    do_sc(32'h1000_0104, 0); go();

    phase = "R3 granule mismatch";
    do_ll(32'h0000_0200);
    do_sc(32'h0000_0210, 0); go();

    phase = "R4 snoop same block";
    do_ll(32'h0000_0300);
    do_snp(32'h0000_033C);
    do_sc(32'h0000_0300, 0); go();
    phase = "R4 snoop other block ignored";
    do_ll(32'h0000_0300);
    do_snp(32'h0000_0340);
    do_sc(32'h0000_030F, 0); go();
    phase = "R4 widened mask";
    blk_mask = 32'hFFFF_FF00;
    do_ll(32'h0000_0300);
    do_snp(32'h0000_03C0);
    do_sc(32'h0000_0300, 0); go();
    phase = "R4 snoop while disarmed";
    do_snp(32'h0000_0300);
    do_ll(32'h0000_0300);
    do_sc(32'h0000_0300, 0); go();
    blk_mask = 32'hFFFF_FFC0;

    phase = "R5 snoop and sc same cycle";
    do_ll(32'h0000_0500);
    snp_valid = 1; snp_addr = 32'h0000_0520;
    do_sc(32'h0000_0500, 0); go();
    phase = "R5 other-block snoop with sc";
    do_ll(32'h0000_0500);
    snp_valid = 1; snp_addr = 32'h0000_0900;
    do_sc(32'h0000_0500, 0); go();

    phase = "R6 uncached bypass";
    do_sc(32'h0000_0999, 1); go();
    do_ll(32'h0000_0600);
    do_sc(32'h0000_0999, 1);
    do_sc(32'h0000_0600, 0); go();
    do_sc(32'h0000_0000, 0);
    do_sc(32'h0000_0040, 1); go();

    phase = "R10 overwrite";
    do_ll(32'h0000_0700);
    do_ll(32'h0000_0800);
    do_sc(32'h0000_0700, 0);
    do_ll(32'h0000_0900);
    do_ll(32'h0000_0A00);
    do_sc(32'h0000_0A08, 0); go();

    phase = "R12 ll and sc same cycle";
    ll_valid = 1; ll_addr = 32'h0000_0B00;
    do_sc(32'h0000_0B00, 0);
    do_sc(32'h0000_0B04, 0); go();
    do_ll(32'h0000_0C00);
    ll_valid = 1; ll_addr = 32'h0000_0D00;
    do_sc(32'h0000_0C00, 0);
    do_sc(32'h0000_0D00, 0); go();

    phase = "R7 R8 fail run and saturation";
    for (int i = 0; i < 20; i++) do_sc(32'h0000_0E00, 0);
    go();
    do_ll(32'h0000_0E00);
    do_sc(32'h0000_0E00, 0); go();
    for (int i = 0; i < 6; i++) do_sc(32'h0000_0E00, 0);
    go();

    phase = "R9 global clear";
    gclr = 1; go();
    go();
    gclr = 1; go();
    gclr = 1; go();
    go(); go();

    done = 1;
    report();
    $finish;
  end

endmodule